// File: doc/BRIEF.md
# Edge-Triggered Single-Channel ADC Sequencer

This block is the digital controller for a four-input analog-to-digital converter when it is driven from an external trigger pin. The trigger pin is synchronized into the system clock domain and passed through an edge filter. The filter can be set to react to rising edges, falling edges, both, or neither. Each accepted edge launches exactly one conversion of the channel that is selected at that moment, provided that conversion is enabled and the trigger-mode field holds the external-trigger code.

The converter core is reached through a start/done handshake. The sequencer pulses `core_start` for one cycle and presents the captured channel on `core_channel`. It then waits for `core_done`, samples the 10-bit result in that cycle and writes it into the result-bank entry whose index equals the captured channel. One cycle later it raises a single-cycle end-of-conversion pulse and goes back to idle. The bank has eight entries; this mode only ever writes entries 0 to 3. Any entry can be read combinationally through `rd_index`/`rd_data`.

The controller has three states. IDLE waits for a trigger. LAUNCH drives the start pulse. WAIT expects the done pulse. Its transitions are:
- ACCEPT: IDLE to LAUNCH, on a valid edge with the block enabled and in external mode.
- ISSUE: LAUNCH to WAIT, always.
- COMPLETE: WAIT to IDLE, on done while enabled.
- ABORT: WAIT to IDLE, when the enable bit is cleared.

Top module: `adc_trig_seq`

## Requirements
- R1: Edge select encoding on `cfg_edge_sel`: 2'b01 accepts rising edges only, 2'b10 falling edges only, 2'b11 both, and 2'b00 no edge. The pin goes through a two-flop synchronizer before edge detection.
- R2: Only the trigger-mode code 3'b110 on `cfg_trig_mode` lets a trigger edge start a conversion. Any other code ignores the pin.
- R3: While `cfg_enable` is 0, trigger edges start no conversion.
- R4: Each accepted edge produces exactly one `core_start` pulse of one cycle. `core_channel` carries the channel that was selected when the edge was accepted.
- R5: The result sampled on `core_done` is written into the bank entry whose index equals the captured channel. Changing `cfg_channel` later does not redirect the write. Entries 4 to 7 stay zero.
- R6: `eoc_irq` is a one-cycle pulse. It is asserted in the first cycle in which the new result is visible on `rd_data`, and once per completed conversion.
- R7: Trigger edges that arrive while a conversion is pending are dropped, not queued.
- R8: Clearing `cfg_enable` while waiting for done aborts the conversion. No bank entry changes and no `eoc_irq` follows, even if the core later reports done.
- R9: After reset all bank entries read zero, `core_start` and `eoc_irq` are low, and the sequencer is in IDLE.
- R10: A `core_done` pulse while no conversion is pending changes no entry and raises no `eoc_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Conversion enable |
| cfg_trig_mode | input | 3 | Trigger-mode code; 3'b110 selects external trigger |
| cfg_edge_sel | input | 2 | Valid-edge select (R1 encoding) |
| cfg_channel | input | 2 | Analog channel to convert |
| trig_pin | input | 1 | Asynchronous external trigger |
| core_start | output | 1 | One-cycle start to the converter core |
| core_channel | output | 2 | Channel being converted |
| core_done | input | 1 | Core completion pulse |
| core_result | input | 10 | Core result, sampled with done |
| eoc_irq | output | 1 | End-of-conversion pulse |
| rd_index | input | 3 | Bank entry to read |
| rd_data | output | 10 | Content of the selected bank entry |

## Verification
The bench drives conversions from rising, falling and both-edge settings on different channels with distinct result values. A wrong edge polarity or a swapped bank index therefore shows up as a mismatched entry. Edges of the unselected polarity, a disabled block, a non-external mode code and the no-edge code are applied next. Together they show which gate fails to block the pin. A burst of edges during a long conversion separates dropping from queuing. A channel change during a conversion shows whether the channel is captured or passed through live. An enable drop mid-conversion followed by a late done, and a stray done while idle, show whether completion is tied to the WAIT state.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam logic [2:0] TRIG_MODE_EXT = 3'b110;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } seq_state_t;
endpackage

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] edge_sel,
    output logic       hit
);
    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
    logic [STAGES:0] sh;
    logic            rise;
    logic            fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], pin};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] & sh[STAGES];
    assign hit  = (edge_sel[0] & rise) | (edge_sel[1] & fall);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit,
    input  logic            enable,
    input  logic [2:0]      mode,
    input  logic [CH_W-1:0] channel,
    input  logic            done,
    output logic            start,
    output logic [CH_W-1:0] cur_ch,
    output logic            wr_en
);
    seq_state_t state, state_nxt;
    logic       accept;

    assign accept = hit && enable && (mode == TRIG_MODE_EXT);

    // state register and channel capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur_ch <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_IDLE && accept) cur_ch <= channel;
        end
    end

    // transitions: ACCEPT, ISSUE, COMPLETE, ABORT
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nxt = ST_LAUNCH;
            ST_LAUNCH: state_nxt = ST_WAIT;
            ST_WAIT:   if (!enable || done) state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start = 1'b0;
        wr_en = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_LAUNCH: start = 1'b1;
            ST_WAIT:   wr_en = enable && done;
            default:   ;
        endcase
    end
endmodule

// File: rtl/result_bank.sv
module result_bank #(
    parameter int N     = 8,
    parameter int W     = 10,
    parameter int CH_W  = 2,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_index,
    output logic [W-1:0]     rd_data,
    output logic             wr_pulse
);
    logic [W-1:0]     mem [N];
    logic [IDX_W-1:0] wr_idx;

    assign wr_idx = IDX_W'(wr_ch);

    for (genvar i = 0; i < N; i++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              mem[i] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))   mem[i] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_pulse <= 1'b0;
        else        wr_pulse <= wr_en;
    end

    assign rd_data = mem[rd_index];
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq #(
    parameter int RES_W       = 10,
    parameter int CH_W        = 2,
    parameter int BANK_N      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_enable,
    input  logic [2:0]                cfg_trig_mode,
    input  logic [1:0]                cfg_edge_sel,
    input  logic [CH_W-1:0]           cfg_channel,
    input  logic                      trig_pin,
    output logic                      core_start,
    output logic [CH_W-1:0]           core_channel,
    input  logic                      core_done,
    input  logic [RES_W-1:0]          core_result,
    output logic                      eoc_irq,
    input  logic [$clog2(BANK_N)-1:0] rd_index,
    output logic [RES_W-1:0]          rd_data
);
    logic hit;
    logic wr_en;

    trig_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (trig_pin),
        .edge_sel (cfg_edge_sel),
        .hit      (hit)
    );

    seq_fsm #(.CH_W(CH_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .enable  (cfg_enable),
        .mode    (cfg_trig_mode),
        .channel (cfg_channel),
        .done    (core_done),
        .start   (core_start),
        .cur_ch  (core_channel),
        .wr_en   (wr_en)
    );

    result_bank #(.N(BANK_N), .W(RES_W), .CH_W(CH_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ch    (core_channel),
        .wr_data  (core_result),
        .rd_index (rd_index),
        .rd_data  (rd_data),
        .wr_pulse (eoc_irq)
    );
endmodule

// File: rtl/adc_trig_seq_chk.sv
module adc_trig_seq_chk #(
    parameter int RES_W  = 10,
    parameter int BANK_N = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_enable,
    input logic [2:0]                cfg_trig_mode,
    input logic                      core_start,
    input logic                      core_done,
    input logic                      eoc_irq,
    input logic [$clog2(BANK_N)-1:0] rd_index,
    input logic [RES_W-1:0]          rd_data
);
    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    // R2
    start_needs_ext_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> $past(cfg_trig_mode) == 3'b110);

    // R3
    start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> $past(cfg_enable));

    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |=> !eoc_irq);

    // R8
    irq_after_enabled_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |-> ($past(core_done) && $past(cfg_enable)));

    // R5
    upper_entries_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_index[$clog2(BANK_N)-1] |-> rd_data == '0);
endmodule

bind adc_trig_seq adc_trig_seq_chk #(.RES_W(RES_W), .BANK_N(BANK_N)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_enable    (cfg_enable),
    .cfg_trig_mode (cfg_trig_mode),
    .core_start    (core_start),
    .core_done     (core_done),
    .eoc_irq       (eoc_irq),
    .rd_index      (rd_index),
    .rd_data       (rd_data)
);

// File: tb/adc_trig_seq_tb.sv
module adc_trig_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b0;
    logic [2:0] cfg_trig_mode = 3'b000;
    logic [1:0] cfg_edge_sel = 2'b01;
    logic [1:0] cfg_channel = 2'd0;
    logic       trig_pin = 1'b0;
    logic       core_start;
    logic [1:0] core_channel;
    logic       core_done;
    logic [9:0] core_result = '0;
    logic       eoc_irq;
    logic [2:0] rd_index;
    logic [9:0] rd_data;

    logic       model_done = 1'b0;
    logic       stray_done = 1'b0;
    logic [9:0] next_result = '0;
    int         core_lat = 3;
    int         start_cnt = 0;
    int         irq_cnt = 0;
    logic [1:0] last_core_ch = '0;
    logic       use_tb = 1'b1;
    logic [2:0] tb_idx = '0;
    logic [2:0] mon_idx = '0;
    logic [9:0] exp_bank [8];

    int checks = 0;
    int errors = 0;

    typedef struct packed { logic [1:0] ch; logic [9:0] val; } exp_t;
    exp_t exp_q [$];

    assign core_done = model_done | stray_done;
    assign rd_index  = use_tb ? tb_idx : mon_idx;

    always #5 clk = ~clk;

    adc_trig_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_trig_mode(cfg_trig_mode), .cfg_edge_sel(cfg_edge_sel),
        .cfg_channel(cfg_channel), .trig_pin(trig_pin),
        .core_start(core_start), .core_channel(core_channel),
        .core_done(core_done), .core_result(core_result),
        .eoc_irq(eoc_irq), .rd_index(rd_index), .rd_data(rd_data)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // converter core model
    always begin
        @(negedge clk);
        if (rst_n && core_start) begin
            start_cnt++;
            last_core_ch = core_channel;
            repeat (core_lat) @(negedge clk);
            core_result = next_result;
            model_done  = 1'b1;
            @(negedge clk);
            model_done  = 1'b0;
        end
    end

    // scoreboard monitor
    always begin
        @(negedge clk);
        if (rst_n && eoc_irq) begin
            irq_cnt++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6/R8/R10 unexpected eoc_irq", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                mon_idx = {1'b0, e.ch};
                #1;
                chk(rd_data == e.val, "R5/R6 entry value at irq", rd_data, e.val);
            end
        end
    end

    task automatic settle();
        repeat (30) @(negedge clk);
    endtask

    task automatic toggle_pin();
        @(negedge clk);
        trig_pin = ~trig_pin;
    endtask

    // expect one conversion of ch with value v on the next pin toggle
    task automatic convert(input logic [1:0] ch, input logic [9:0] v, input string req);
        int s0;
        s0 = start_cnt;
        cfg_channel = ch;
        next_result = v;
        exp_q.push_back('{ch: ch, val: v});
        exp_bank[ch] = v;
        toggle_pin();
        settle();
        chk(start_cnt == s0 + 1, req, start_cnt - s0, 1);
        chk(last_core_ch == ch, "R4 core_channel", last_core_ch, ch);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic no_convert(input string req);
        int s0, i0;
        s0 = start_cnt;
        i0 = irq_cnt;
        toggle_pin();
        settle();
        chk(start_cnt == s0, req, start_cnt - s0, 0);
        chk(irq_cnt == i0, req, irq_cnt - i0, 0);
    endtask

    task automatic check_bank(input string req);
        use_tb = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tb_idx = 3'(i);
            #1;
            chk(rd_data == exp_bank[i], req, rd_data, exp_bank[i]);
        end
        use_tb = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) exp_bank[i] = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(core_start == 1'b0, "R9 core_start low", core_start, 0);
        chk(eoc_irq == 1'b0, "R9 eoc_irq low", eoc_irq, 0);
        check_bank("R9 bank zero in reset");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_bank("R9 bank zero after reset");

        cfg_enable    = 1'b1;
        cfg_trig_mode = 3'b110;

        // R1 rising edge
        cfg_edge_sel = 2'b01;
        convert(2'd2, 10'h2A5, "R1 rising conversion");
        // R1 falling edge (pin is high)
        cfg_edge_sel = 2'b10;
        convert(2'd1, 10'h13C, "R1 falling conversion");
        // R1 both edges
        cfg_edge_sel = 2'b11;
        convert(2'd0, 10'h3FF, "R1 both: rise");
        convert(2'd3, 10'h001, "R1 both: fall");
        // R1 wrong polarity and no-edge code (pin low now)
        cfg_edge_sel = 2'b10;
        no_convert("R1 rise ignored when falling selected");
        cfg_edge_sel = 2'b01;
        no_convert("R1 fall ignored when rising selected");
        cfg_edge_sel = 2'b00;
        no_convert("R1 no edge code");
        no_convert("R1 no edge code");
        // R2 mode gating
        cfg_edge_sel  = 2'b11;
        cfg_trig_mode = 3'b011;
        no_convert("R2 non-external mode");
        cfg_trig_mode = 3'b111;
        no_convert("R2 non-external mode");
        cfg_trig_mode = 3'b110;
        // R3 enable gating
        cfg_enable = 1'b0;
        no_convert("R3 disabled");
        cfg_enable = 1'b1;
        check_bank("R2/R3 bank untouched");

        // R7 burst during a long conversion
        begin
            int s0;
            core_lat = 12;
            s0 = start_cnt;
            cfg_channel = 2'd1;
            next_result = 10'h155;
            exp_q.push_back('{ch: 2'd1, val: 10'h155});
            exp_bank[1] = 10'h155;
            toggle_pin();
            repeat (5) @(negedge clk);
            toggle_pin();
            toggle_pin();
            toggle_pin();
            settle();
            chk(start_cnt == s0 + 1, "R7 one start for burst", start_cnt - s0, 1);
            chk(exp_q.size() == 0, "R7 single irq", exp_q.size(), 0);
        end

        // R5 channel change mid-conversion does not redirect
        begin
            cfg_channel = 2'd0;
            next_result = 10'h0AA;
            exp_q.push_back('{ch: 2'd0, val: 10'h0AA});
            exp_bank[0] = 10'h0AA;
            toggle_pin();
            repeat (6) @(negedge clk);
            cfg_channel = 2'd3;
            settle();
            chk(last_core_ch == 2'd0, "R5 captured channel", last_core_ch, 0);
            check_bank("R5 write follows captured channel");
        end

        // R8 abort by clearing enable
        begin
            int i0;
            i0 = irq_cnt;
            cfg_channel = 2'd2;
            next_result = 10'h321;
            toggle_pin();
            repeat (6) @(negedge clk);
            cfg_enable = 1'b0;
            settle();
            chk(irq_cnt == i0, "R8 no irq after abort", irq_cnt - i0, 0);
            check_bank("R8 bank unchanged after abort");
            cfg_enable = 1'b1;
        end

        // R10 stray done while idle
        begin
            int i0;
            i0 = irq_cnt;
            core_lat = 3;
            @(negedge clk);
            stray_done = 1'b1;
            @(negedge clk);
            stray_done = 1'b0;
            settle();
            chk(irq_cnt == i0, "R10 stray done ignored", irq_cnt - i0, 0);
            check_bank("R10 bank unchanged");
        end

        // normal operation resumes after abort
        convert(2'd3, 10'h2C7, "R4 conversion after abort");
        check_bank("R5 final bank, upper entries zero");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule